// File: doc/BRIEF.md
# Seconds Counter with Alarm Compare

This peripheral keeps elapsed time as a 32-bit count of seconds on a slow clock domain (nominally 32.768 kHz). A prescaler divides the clock down to one pulse per second. Each pulse advances the count and raises a once-per-second flag. A 32-bit compare register raises an alarm flag when the count equals it. Each flag has its own interrupt enable, and the interrupt output is registered.

Software reaches the block through a simple 32-bit register bus with a write strobe, a read strobe and read data returned one cycle after the read strobe. Writes are protected twice. First, a key must be written to an unlock register, and one key allows exactly one write. Second, each accepted write makes the block report "not ready" for a fixed number of cycles, and writes issued while not ready are dropped. The status flags are sticky. A write clears a flag only where the written bit is 0, so software writes 1 to a flag bit to keep it. A general scratch word lets software store a marker that says the time is valid.

Top module: `rtc_seconds_alarm`

## Requirements
- R1: After reset, control reads 0x00000080 (ready set, everything else clear). Seconds, alarm, scratch and the unlock register read 0, and `irq` is 0.
- R2: Register offsets are: control 0x00, seconds 0x04, alarm 0x08, scratch 0x34, unlock 0x3C. `bus_rdata` holds the addressed register one cycle after `bus_re`, any other offset reads 0, and `bus_rdata` keeps its value while `bus_re` is low.
- R3: A write to 0x3C whose low 16 bits are 0xA55A, made while ready, sets the unlock bit (bit 31 of 0x3C). A write of any other value leaves the unlock bit unchanged.
- R4: A write to any offset other than 0x3C takes effect only when ready is 1 and the unlock bit is 1. Otherwise it changes no register.
- R5: After an accepted write, ready (control bit 7) reads 0 for BUSY_CYCLES cycles and the unlock bit reads 0. A key write made while not ready is ignored.
- R6: While the run bit (control bit 0) is 1, seconds advances by one every TICK_DIV clocks. While it is 0, seconds holds. Writing seconds restarts the divider.
- R7: The 1 Hz flag (control bit 6) is set on every advance. The alarm flag (control bit 4) is set when the alarm enable (control bit 2) is 1 and seconds equals alarm. With the alarm enable at 0, the alarm flag is not set.
- R8: An accepted control write clears a flag whose written bit is 0 and keeps a flag whose written bit is 1. A set event in the same cycle wins over the clear.
- R9: `irq` equals, one cycle later, (1 Hz flag AND control bit 5) OR (alarm flag AND control bit 3).
- R10: Seconds wraps from 0xFFFFFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with TICK_DIV = 8 and BUSY_CYCLES = 3. With these values a counter advance happens every eight cycles, so alarm matches, the sticky flags and the wrap from 0xFFFFFFFF to 0 all occur within a few dozen cycles. The short busy window also lets the bench try a key write inside it and observe that the key is dropped. A behavioural model of the register file is compared with `bus_rdata` and `irq` on every cycle, alongside directed reads with hand-computed values.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DW = 32;

  localparam logic [7:0] OFS_CTRL    = 8'h00;
  localparam logic [7:0] OFS_SECONDS = 8'h04;
  localparam logic [7:0] OFS_ALARM   = 8'h08;
  localparam logic [7:0] OFS_SCRATCH = 8'h34;
  localparam logic [7:0] OFS_UNLOCK  = 8'h3C;

  localparam int BIT_RUN      = 0;
  localparam int BIT_AL_EN    = 2;
  localparam int BIT_AL_IE    = 3;
  localparam int BIT_AL_FLAG  = 4;
  localparam int BIT_HZ_IE    = 5;
  localparam int BIT_HZ_FLAG  = 6;
  localparam int BIT_READY    = 7;
  localparam int BIT_UNLOCKED = 31;

  localparam logic [15:0] DEFAULT_KEY = 16'hA55A;
endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
  parameter int TICK_DIV = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) cnt <= '0;
    else if (tick)              cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rtc_write_guard.sv
module rtc_write_guard #(
  parameter int          BUSY_CYCLES = 4,
  parameter logic [15:0] KEY         = 16'hA55A,
  parameter bit          USE_UNLOCK  = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  logic        to_unlock,
  input  logic [15:0] wdata_lo,
  output logic        ready,
  output logic        unlocked,
  output logic        accept
);
  localparam int BW = $clog2(BUSY_CYCLES + 1);
  localparam logic [BW-1:0] BUSY_LOAD = BW'(BUSY_CYCLES);

  logic [BW-1:0] busy;

  assign ready = (busy == '0);

  generate
    if (USE_UNLOCK) begin : g_keyed
      logic unl_q;
      assign accept   = we && !to_unlock && ready && unl_q;
      assign unlocked = unl_q;
      always_ff @(posedge clk) begin
        if (rst)                                         unl_q <= 1'b0;
        else if (we && to_unlock && ready && wdata_lo == KEY) unl_q <= 1'b1;
        else if (accept)                                 unl_q <= 1'b0;
      end
    end else begin : g_open
      assign accept   = we && !to_unlock && ready;
      assign unlocked = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          busy <= '0;
    else if (accept)  busy <= BUSY_LOAD;
    else if (!ready)  busy <= busy - 1'b1;
  end
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         load_sec,
  input  logic         load_alarm,
  input  logic [W-1:0] wdata,
  input  logic         alarm_en,
  input  logic         clr_hz,
  input  logic         clr_al,
  output logic [W-1:0] seconds,
  output logic [W-1:0] alarm,
  output logic         hz_flag,
  output logic         al_flag
);
  logic match;
  assign match = alarm_en && (seconds == alarm);

  always_ff @(posedge clk) begin
    if (rst) begin
      seconds <= '0;
      alarm   <= '0;
      hz_flag <= 1'b0;
      al_flag <= 1'b0;
    end else begin
      if (load_sec)  seconds <= wdata;
      else if (tick) seconds <= seconds + 1'b1;
      if (load_alarm) alarm <= wdata;
      hz_flag <= (hz_flag && !clr_hz) || tick;
      al_flag <= (al_flag && !clr_al) || match;
    end
  end
endmodule

// File: rtl/rtc_seconds_alarm.sv
module rtc_seconds_alarm
  import rtc_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          TICK_DIV    = 32768,
  parameter int          BUSY_CYCLES = 4,
  parameter logic [15:0] UNLOCK_KEY  = DEFAULT_KEY,
  parameter bit          USE_UNLOCK  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq
);
  logic hit_ctrl, hit_sec, hit_alarm, hit_scratch, hit_unlock;
  assign hit_ctrl    = (bus_addr == ADDR_W'(OFS_CTRL));
  assign hit_sec     = (bus_addr == ADDR_W'(OFS_SECONDS));
  assign hit_alarm   = (bus_addr == ADDR_W'(OFS_ALARM));
  assign hit_scratch = (bus_addr == ADDR_W'(OFS_SCRATCH));
  assign hit_unlock  = (bus_addr == ADDR_W'(OFS_UNLOCK));

  logic wr_ready, unlocked, wr_accept, tick;
  logic run_q, al_en_q, al_ie_q, hz_ie_q;
  logic [DW-1:0] seconds, alarm, scratch_q;
  logic hz_flag, al_flag;
  logic ctrl_wr;

  assign ctrl_wr = wr_accept && hit_ctrl;

  rtc_write_guard #(
    .BUSY_CYCLES(BUSY_CYCLES), .KEY(UNLOCK_KEY), .USE_UNLOCK(USE_UNLOCK)
  ) u_guard (
    .clk(clk), .rst(rst), .we(bus_we), .to_unlock(hit_unlock),
    .wdata_lo(bus_wdata[15:0]), .ready(wr_ready), .unlocked(unlocked),
    .accept(wr_accept)
  );

  rtc_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .run(run_q), .restart(wr_accept && hit_sec),
    .tick(tick)
  );

  rtc_time_core #(.W(DW)) u_core (
    .clk(clk), .rst(rst), .tick(tick),
    .load_sec(wr_accept && hit_sec), .load_alarm(wr_accept && hit_alarm),
    .wdata(bus_wdata), .alarm_en(al_en_q),
    .clr_hz(ctrl_wr && !bus_wdata[BIT_HZ_FLAG]),
    .clr_al(ctrl_wr && !bus_wdata[BIT_AL_FLAG]),
    .seconds(seconds), .alarm(alarm), .hz_flag(hz_flag), .al_flag(al_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0; al_en_q <= 1'b0; al_ie_q <= 1'b0; hz_ie_q <= 1'b0;
      scratch_q <= '0;
    end else begin
      if (ctrl_wr) begin
        run_q   <= bus_wdata[BIT_RUN];
        al_en_q <= bus_wdata[BIT_AL_EN];
        al_ie_q <= bus_wdata[BIT_AL_IE];
        hz_ie_q <= bus_wdata[BIT_HZ_IE];
      end
      if (wr_accept && hit_scratch) scratch_q <= bus_wdata;
    end
  end

  logic [DW-1:0] ctrl_word, rd_mux;
  always_comb begin
    ctrl_word = '0;
    ctrl_word[BIT_RUN]     = run_q;
    ctrl_word[BIT_AL_EN]   = al_en_q;
    ctrl_word[BIT_AL_IE]   = al_ie_q;
    ctrl_word[BIT_AL_FLAG] = al_flag;
    ctrl_word[BIT_HZ_IE]   = hz_ie_q;
    ctrl_word[BIT_HZ_FLAG] = hz_flag;
    ctrl_word[BIT_READY]   = wr_ready;
    rd_mux = '0;
    if (hit_ctrl)    rd_mux = ctrl_word;
    if (hit_sec)     rd_mux = seconds;
    if (hit_alarm)   rd_mux = alarm;
    if (hit_scratch) rd_mux = scratch_q;
    if (hit_unlock)  rd_mux[BIT_UNLOCKED] = unlocked;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (bus_re) bus_rdata <= rd_mux;
      irq <= (hz_flag && hz_ie_q) || (al_flag && al_ie_q);
    end
  end
endmodule

// File: rtl/rtc_seconds_alarm_chk.sv
module rtc_seconds_alarm_chk #(
  parameter int ADDR_W     = 8,
  parameter bit USE_UNLOCK = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wr_ready,
  input logic              wr_accept,
  input logic              unlocked,
  input logic              tick,
  input logic [31:0]       seconds,
  input logic [31:0]       scratch_q,
  input logic              run_q,
  input logic              hz_ie_q,
  input logic              al_ie_q,
  input logic              irq
);
  localparam logic [ADDR_W-1:0] A_SEC = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_SCR = ADDR_W'(8'h34);

  logic sec_load;
  assign sec_load = wr_accept && (bus_addr == A_SEC);

  p_ready_drops_r5: assert property (@(posedge clk) disable iff (rst)
    wr_accept |=> !wr_ready);

  p_unlock_consumed_r5: assert property (@(posedge clk) disable iff (rst)
    wr_accept |=> (!unlocked || !USE_UNLOCK));

  p_blocked_write_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_SCR && (!wr_ready || (USE_UNLOCK && !unlocked)))
      |=> $stable(scratch_q));

  p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
    (tick && !sec_load) |=> (seconds == $past(seconds) + 32'd1));

  p_count_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !sec_load) |=> $stable(seconds));

  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (!hz_ie_q && !al_ie_q) |=> !irq);
endmodule

bind rtc_seconds_alarm rtc_seconds_alarm_chk #(
  .ADDR_W(ADDR_W), .USE_UNLOCK(USE_UNLOCK)
) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .wr_ready(wr_ready), .wr_accept(wr_accept), .unlocked(unlocked),
  .tick(tick), .seconds(seconds), .scratch_q(scratch_q), .run_q(run_q),
  .hz_ie_q(hz_ie_q), .al_ie_q(al_ie_q), .irq(irq)
);

// File: tb/rtc_seconds_alarm_tb.sv
module rtc_seconds_alarm_tb;
  localparam int TD   = 8;
  localparam int BUSY = 3;
  localparam logic [7:0] A_CTRL = 8'h00, A_SEC = 8'h04, A_ALM = 8'h08,
                         A_SCR = 8'h34, A_UNL = 8'h3C, A_GAP = 8'h0C;
  localparam logic [31:0] KEY = 32'h0000A55A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_checks = 0, n_errors = 0, cyc = 0;

  always #4 clk = ~clk;

  rtc_seconds_alarm #(.ADDR_W(8), .TICK_DIV(TD), .BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int          m_presc, m_busy;
  logic [31:0] m_sec, m_alm, m_scr, m_rdata;
  logic        m_run, m_ae, m_aie, m_hie, m_hf, m_af, m_unl, m_irq;

  always @(posedge clk) begin : model
    logic rdy, acc, tk;
    logic [31:0] cw;
    if (rst) begin
      m_presc <= 0; m_busy <= 0; m_sec <= 0; m_alm <= 0; m_scr <= 0;
      m_rdata <= 0; m_run <= 0; m_ae <= 0; m_aie <= 0; m_hie <= 0;
      m_hf <= 0; m_af <= 0; m_unl <= 0; m_irq <= 0;
    end else begin
      rdy = (m_busy == 0);
      acc = bus_we && rdy && m_unl && bus_addr != A_UNL;
      tk  = m_run && m_presc == TD - 1;
      cw  = {24'h0, rdy, m_hf, m_hie, m_af, m_aie, m_ae, 1'b0, m_run};
      if (bus_re)
        case (bus_addr)
          A_CTRL:  m_rdata <= cw;
          A_SEC:   m_rdata <= m_sec;
          A_ALM:   m_rdata <= m_alm;
          A_SCR:   m_rdata <= m_scr;
          A_UNL:   m_rdata <= {m_unl, 31'h0};
          default: m_rdata <= 32'h0;
        endcase
      m_irq   <= (m_hf && m_hie) || (m_af && m_aie);
      m_presc <= (!m_run || (acc && bus_addr == A_SEC) || tk) ? 0 : m_presc + 1;
      m_sec   <= (acc && bus_addr == A_SEC) ? bus_wdata : (tk ? m_sec + 1 : m_sec);
      if (acc && bus_addr == A_ALM) m_alm <= bus_wdata;
      if (acc && bus_addr == A_SCR) m_scr <= bus_wdata;
      m_hf <= (m_hf && !(acc && bus_addr == A_CTRL && !bus_wdata[6])) || tk;
      m_af <= (m_af && !(acc && bus_addr == A_CTRL && !bus_wdata[4])) ||
              (m_ae && m_sec == m_alm);
      if (acc && bus_addr == A_CTRL) begin
        m_run <= bus_wdata[0]; m_ae <= bus_wdata[2];
        m_aie <= bus_wdata[3]; m_hie <= bus_wdata[5];
      end
      m_busy <= acc ? BUSY : (m_busy > 0 ? m_busy - 1 : 0);
      if (bus_we && bus_addr == A_UNL && rdy && bus_wdata[15:0] == KEY[15:0]) m_unl <= 1;
      else if (acc) m_unl <= 0;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check("R2 model rdata", bus_rdata, m_rdata);
      check("R9 model irq", {31'h0, irq}, {31'h0, m_irq});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic wr_unl(input logic [7:0] a, input logic [31:0] d);
    repeat (BUSY + 1) @(negedge clk);
    wr(A_UNL, KEY);
    wr(a, d);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_re = 1'b1; bus_addr = a;
    @(negedge clk); bus_re = 1'b0; d = bus_rdata;
  endtask

  task automatic stop_clock();
    wr_unl(A_CTRL, 32'h40);
    wr_unl(A_CTRL, 32'h00);
  endtask

  initial begin
    logic [31:0] v, v2;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(A_CTRL, v); check("R1 ctrl", v, 32'h80);
    rd(A_SEC, v);  check("R1 seconds", v, 32'h0);
    rd(A_ALM, v);  check("R1 alarm", v, 32'h0);
    rd(A_SCR, v);  check("R1 scratch", v, 32'h0);
    rd(A_UNL, v);  check("R1 unlock", v, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);

    // R4 locked write dropped; R3 wrong key then right key
    wr(A_SCR, 32'h12345678);
    rd(A_SCR, v); check("R4 locked write", v, 32'h0);
    wr(A_UNL, 32'h00001234);
    rd(A_UNL, v); check("R3 wrong key", v, 32'h0);
    wr(A_UNL, KEY);
    rd(A_UNL, v); check("R3 key sets bit31", v, 32'h80000000);

    // R5 busy window and unlock consumed
    wr(A_SCR, 32'h12345678);
    rd(A_CTRL, v); check("R5 ready low", v, 32'h0);
    rd(A_UNL, v);  check("R5 unlock consumed", v, 32'h0);
    rd(A_SCR, v);  check("R2 scratch", v, 32'h12345678);
    rd(A_GAP, v);  check("R2 unmapped", v, 32'h0);

    // R5 key while busy ignored, R4 later write dropped
    wr_unl(A_SCR, 32'hCAFE0001);
    wr(A_UNL, KEY);
    rd(A_UNL, v); check("R5 key while busy", v, 32'h0);
    repeat (BUSY + 1) @(negedge clk);
    wr(A_SCR, 32'hDEAD0002);
    rd(A_SCR, v); check("R4 write after busy no key", v, 32'hCAFE0001);

    // R6 counting
    wr_unl(A_SEC, 32'd100);
    wr_unl(A_CTRL, 32'h01);
    repeat (40) @(negedge clk);
    rd(A_SEC, v); check("R6 advance", v, 32'd105);
    rd(A_CTRL, v); check("R7 hz flag", v, 32'hC1);

    // R8 keep with 1, then clear with 0; R6 hold when stopped
    wr_unl(A_CTRL, 32'h40);
    rd(A_CTRL, v); check("R8 keep flag", v & 32'h40, 32'h40);
    wr_unl(A_CTRL, 32'h00);
    rd(A_CTRL, v); check("R8 clear flag", v & 32'h7F, 32'h0);
    rd(A_SEC, v); repeat (30) @(negedge clk); rd(A_SEC, v2);
    check("R6 hold", v2, v);

    // R7 alarm match, R9 irq
    wr_unl(A_SEC, 32'd200);
    wr_unl(A_ALM, 32'd203);
    wr_unl(A_CTRL, 32'h0D);
    repeat (40) @(negedge clk);
    rd(A_CTRL, v); check("R7 alarm flag", v, 32'hDD);
    check("R9 alarm irq", {31'h0, irq}, 32'h1);
    wr_unl(A_CTRL, 32'h4D);
    rd(A_CTRL, v); check("R8 alarm cleared", v & 32'h10, 32'h0);
    repeat (2) @(negedge clk);
    check("R9 irq drops", {31'h0, irq}, 32'h0);
    wr_unl(A_CTRL, 32'h21);
    repeat (20) @(negedge clk);
    check("R9 hz irq", {31'h0, irq}, 32'h1);

    // R7 no alarm flag without enable
    stop_clock();
    wr_unl(A_SEC, 32'd300);
    wr_unl(A_ALM, 32'd302);
    wr_unl(A_CTRL, 32'h01);
    repeat (40) @(negedge clk);
    rd(A_CTRL, v); check("R7 alarm disabled", v & 32'h10, 32'h0);

    // R10 wrap
    stop_clock();
    wr_unl(A_SEC, 32'hFFFFFFFE);
    wr_unl(A_CTRL, 32'h01);
    repeat (20) @(negedge clk);
    rd(A_SEC, v); check("R10 wrap", v, 32'h0);

    repeat (5) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule